// File: doc/BRIEF.md
# Serial Register Access Port with Pipelined Reads

This block lets an external serial master read and write a bank of 16-bit registers that are addressed by byte. The master sends fixed 16-bit frames using SPI mode 3, with the clock idling high and data sampled on its rising edge. Each frame carries a direction flag, a 7-bit byte address and one data byte. The block synchronises the serial pins into the system clock domain and assembles each frame. It then issues either a one-cycle byte write strobe or a one-cycle register read request on a simple parallel port toward the register bank.

Reads are pipelined by one frame. The register named in a read frame is shifted back to the master during the frame that follows. The master can use that same frame to send its next command, so a stream of reads costs one frame per register plus one frame to start. Writes change one byte of a register per frame. For a read, either byte address of a register selects the same register.

Top module: `spi_regbank_slave`

## Requirements
- R1: Frames are 16 bits long and sent most significant bit first. The block samples `mosi` on rising edges of `sck` while `cs_n` is low, and it changes `miso` only after falling edges.
- R2: Bit 15 of a frame is the direction flag (1 = write, 0 = read). Bits 14..8 hold the byte address and bits 7..0 hold the data byte.
- R3: A complete write frame produces one `wr_stb` pulse that carries the byte address and the data byte. An even address selects the low byte of register address/2 and an odd address selects its high byte. For example, frame 0xCB01 sets bit 8 of register index 0x25 and leaves its low byte unchanged.
- R4: A complete read frame produces one `rd_req` pulse with `rd_index` equal to the byte address shifted right by one, so addresses 0x04 and 0x05 both give index 2. The bank returns `rd_data` in the cycle after `rd_req`.
- R5: The 16-bit value that a read frame fetches is shifted out on `miso`, MSB first, during the next frame.
- R6: The block is full duplex: a frame that returns earlier read data is decoded as a new command in its own right.
- R7: The first frame after reset and any frame that follows a write frame shift out 0x0000.
- R8: If `cs_n` rises before 16 rising clock edges, the frame is discarded. It issues no strobe and no request, and the next full frame still returns the response that was pending before it.
- R9: `miso` is driven low while the block is not selected.
- R10: `wr_stb` and `rd_req` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low (asynchronous) |
| sck | input | 1 | Serial clock, idles high (asynchronous) |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_byte_addr | output | 7 | Byte address of the write |
| wr_byte_data | output | 8 | Data byte of the write |
| rd_req | output | 1 | One-cycle register read request |
| rd_index | output | 6 | Register index of the read |
| rd_data | input | 16 | Register value, valid the cycle after rd_req |

## Verification
The bench uses the default parameters: a 7-bit address, 8-bit data and two synchroniser stages. This gives the full 64-register index space and the exact 16-bit frame layout. The serial clock runs at one twelfth-half-period ratio to the system clock, which leaves enough margin for the synchroniser latency. The bench then checks register-index folding of odd and even addresses, the high-byte write at 0x4B, chained full-duplex reads, and a truncated frame inserted between a read and its response.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } frame_dir_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int N_SIG  = 3,
  parameter int STAGES = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] async_in,
  output logic [N_SIG-1:0] sync_out
);
  logic [N_SIG-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [N_SIG-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rb_rx.sv
module spi_rb_rx #(
  parameter int FRAME_W = 16,
  localparam int CW = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sck_rise,
  input  logic               mosi_s,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame,
  output logic               mid_frame
);
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d = '0;
    end else if (sck_rise && (cnt_q < CW'(FRAME_W))) begin
      sh_d   = {sh_q[FRAME_W-2:0], mosi_s};
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CW'(FRAME_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(FRAME_W);
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign frame_done = done_q;
  assign frame      = sh_q;
  assign mid_frame  = (cnt_q != '0) && (cnt_q < CW'(FRAME_W));
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             shift,
  output logic             miso
);
  logic [REG_W-1:0] sh_q, sh_d;
  logic             miso_q, miso_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {sh_q[REG_W-2:0], 1'b0};
    miso_d = cs_act ? sh_d[REG_W-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      miso_q <= miso_d;
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = 1 + ADDR_W + BYTE_W,
  localparam int REG_W   = 2 * BYTE_W,
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_byte_addr,
  output logic [BYTE_W-1:0] wr_byte_data,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_index,
  input  logic [REG_W-1:0]  rd_data
);
  logic cs_n_s, sck_s, mosi_s;
  logic sck_q, cs_act_q;
  logic cs_act, start, sck_rise, sck_fall;
  logic frame_done, mid_frame;
  logic [FRAME_W-1:0] frame;
  frame_dir_e dir;

  logic              wr_stb_q, wr_stb_d, rd_req_q, rd_req_d, cap_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic [IDX_W-1:0]  rd_idx_q;
  logic [REG_W-1:0]  resp_q, resp_d;

  spi_rb_sync #(.N_SIG(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({cs_n, sck, mosi}),
    .sync_out({cs_n_s, sck_s, mosi_s})
  );

  assign cs_act   = ~cs_n_s;
  assign start    = cs_act & ~cs_act_q;
  assign sck_rise = cs_act & sck_s & ~sck_q;
  assign sck_fall = cs_act & ~sck_s & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b1;
      cs_act_q <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      cs_act_q <= cs_act;
    end
  end

  spi_rb_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .frame_done(frame_done), .frame(frame),
    .mid_frame(mid_frame)
  );

  spi_rb_tx #(.REG_W(REG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .load(start),
    .load_val(resp_q), .shift(sck_fall & mid_frame), .miso(miso)
  );

  // Command decode and response tracking
  assign dir = frame_dir_e'(frame[FRAME_W-1]);

  always_comb begin
    wr_stb_d = frame_done && (dir == DIR_WRITE);
    rd_req_d = frame_done && (dir == DIR_READ);
    resp_d   = resp_q;
    if (wr_stb_q)   resp_d = '0;
    else if (cap_q) resp_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      cap_q     <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_idx_q  <= '0;
      resp_q    <= '0;
    end else begin
      wr_stb_q <= wr_stb_d;
      rd_req_q <= rd_req_d;
      cap_q    <= rd_req_q;
      resp_q   <= resp_d;
      if (wr_stb_d) begin
        wr_addr_q <= frame[FRAME_W-2 -: ADDR_W];
        wr_data_q <= frame[BYTE_W-1:0];
      end
      if (rd_req_d) rd_idx_q <= frame[FRAME_W-2 -: IDX_W];
    end
  end

  assign wr_stb       = wr_stb_q;
  assign wr_byte_addr = wr_addr_q;
  assign wr_byte_data = wr_data_q;
  assign rd_req       = rd_req_q;
  assign rd_index     = rd_idx_q;
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             miso,
  input logic             wr_stb,
  input logic             rd_req,
  input logic [IDX_W-1:0] rd_index
);
  // R10
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_req}));
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_act) |-> !miso);
  // R4
  rd_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $stable(rd_index));
endmodule

bind spi_regbank_slave spi_regbank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso(miso),
  .wr_stb(wr_stb), .rd_req(rd_req), .rd_index(rd_index)
);

// File: tb/sim_spi_regbank_slave.sv
`timescale 1ns/1ps
module sim_spi_regbank_slave;
  localparam time HALF = 60ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, mosi = 1'b0;
  logic miso, wr_stb, rd_req;
  logic [6:0]  wr_byte_addr;
  logic [7:0]  wr_byte_data;
  logic [5:0]  rd_index;
  logic [15:0] rd_data;
  logic [15:0] bank [64];

  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, pulse_err = 0;
  logic [6:0] last_wa; logic [7:0] last_wd; logic [5:0] last_ri;
  logic prev_wr = 1'b0, prev_rd = 1'b0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  spi_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .wr_stb(wr_stb), .wr_byte_addr(wr_byte_addr),
    .wr_byte_data(wr_byte_data), .rd_req(rd_req), .rd_index(rd_index),
    .rd_data(rd_data)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 16'h0203) ^ 16'h5A00;
  endfunction

  initial for (int i = 0; i < 64; i++) bank[i] = init_val(i);

  // Register bank model and strobe monitor
  always @(posedge clk) begin
    if (wr_stb) begin
      if (wr_byte_addr[0]) bank[wr_byte_addr[6:1]][15:8] <= wr_byte_data;
      else                 bank[wr_byte_addr[6:1]][7:0]  <= wr_byte_data;
      wr_cnt <= wr_cnt + 1; last_wa <= wr_byte_addr; last_wd <= wr_byte_data;
    end
    if (rd_req) begin
      rd_data <= bank[rd_index];
      rd_cnt <= rd_cnt + 1; last_ri <= rd_index;
    end
    if ((wr_stb && rd_req) || (wr_stb && prev_wr) || (rd_req && prev_rd))
      pulse_err <= pulse_err + 1;
    prev_wr <= wr_stb; prev_rd <= rd_req;
  end

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] cmd, output logic [15:0] resp,
                       input int nbits = 16);
    resp = '0;
    cs_n = 1'b0;
    #HALF;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; mosi = cmd[15-i];
      #HALF;
      resp[15-i] = miso;
      sck = 1'b1;
      #HALF;
    end
    cs_n = 1'b1;
    #(HALF*4);
  endtask

  task automatic t_reset;
    check(miso == 1'b0, "R9 miso idle after reset", 16'(miso), 16'h0);
    check(wr_cnt == 0 && rd_cnt == 0, "R10 no strobes after reset",
          16'(wr_cnt + rd_cnt), 16'h0);
  endtask

  task automatic t_read_chain;
    logic [15:0] r;
    frame(16'h0400, r);
    check(r == 16'h0000, "R7 first frame after reset", r, 16'h0);
    check(rd_cnt == 1 && last_ri == 6'd2, "R4 index from even address", 16'(last_ri), 16'h2);
    frame(16'h0500, r);
    check(r == init_val(2), "R5 read data next frame", r, init_val(2));
    check(rd_cnt == 2 && last_ri == 6'd2, "R4 index from odd address", 16'(last_ri), 16'h2);
    frame(16'h3700, r);
    check(r == init_val(2), "R6 full duplex chain", r, init_val(2));
    frame(16'h0000, r);
    check(r == init_val(27), "R1 MSB-first response", r, init_val(27));
    check(miso == 1'b0, "R9 miso low between frames", 16'(miso), 16'h0);
  endtask

  task automatic t_write_high;
    logic [15:0] r, e;
    frame(16'hCB01, r);
    check(r == init_val(0), "R6 response during write frame", r, init_val(0));
    check(last_wa == 7'h4B && last_wd == 8'h01, "R3 write address and data",
          {1'b0, last_wa, last_wd}, 16'h4B01);
    frame(16'h4A00, r);
    check(r == 16'h0000, "R7 frame after write returns zero", r, 16'h0);
    frame(16'h0000, r);
    e = {8'h01, init_val(37)[7:0]};
    check(r == e, "R3 high byte written, low kept", r, e);
  endtask

  task automatic t_write_low;
    logic [15:0] r, e;
    frame(16'hA05C, r);
    check(wr_cnt == 2 && last_wa == 7'h20, "R2 write flag and address decode",
          {9'h0, last_wa}, 16'h20);
    frame(16'h2100, r);
    frame(16'h0000, r);
    e = {init_val(16)[15:8], 8'h5C};
    check(r == e, "R3 low byte written, high kept", r, e);
  endtask

  task automatic t_abort;
    logic [15:0] r;
    int w0, r0;
    frame(16'h1200, r);
    w0 = wr_cnt; r0 = rd_cnt;
    frame(16'hC3AA, r, 9);
    check(wr_cnt == w0 && rd_cnt == r0, "R8 short frame no access",
          16'(wr_cnt + rd_cnt), 16'(w0 + r0));
    check(bank[33] == init_val(33), "R8 short write left register", bank[33], init_val(33));
    frame(16'h0000, r);
    check(r == init_val(9), "R8 pending response survives", r, init_val(9));
  endtask

  initial begin
    #(HALF*2);
    rst_n = 1'b1;
    #(HALF*2);
    t_reset();
    t_read_chain();
    t_write_high();
    t_write_low();
    t_abort();
    check(pulse_err == 0, "R10 strobes single and exclusive", 16'(pulse_err), 16'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule